// File: doc/BRIEF.md
# Level-Checked Byte FIFO with Selectable Access Width

This block is a 256-byte first-in first-out buffer that sits between a register interface and a serial shift engine. Data enters and leaves in units of one, two or four bytes. A control code picks the unit. A wide unit is stored as consecutive bytes, least significant byte first. Because the store is always a byte array, a word pushed in word mode can be drained later as halves or single bytes in the same order.

The parameter `IS_TX` sets the direction. When it is 1 the register side pushes and the engine side pops. When it is 0 the engine pushes and the register side pops. A two-state run controller (`ST_STOPPED`, `ST_RUNNING`) gates the engine side only; the register side works in either state.

The status word carries a byte-count level and full/empty bits. A threshold comparator and three word-granular level marks (stop, low, high) drive event outputs for a separate interrupt block. A push into a full buffer and a pop from an empty one are both refused, and each raises a one-cycle error pulse.

Controller transitions:
- `ST_STOPPED` goes to `ST_RUNNING` on an operation write with the start bit set (START).
- `ST_RUNNING` goes to `ST_STOPPED` on an operation write with the start bit clear (HALT).
- Every other cycle holds the current state.
- The flush bit acts in either state and does not change the state.

Top module: `lvlfifo_top`

## Requirements
- R1: After reset the status word is 10'h200 (level 0, empty set, full clear), `eng_ready` is low, `err_pulse` is low, and the controller is in `ST_STOPPED`.
- R2: Control bits [1:0] select the unit: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 behaves as four bytes. A push stores the low bytes of the data, least significant first. A pop returns the next bytes in the same order, zero-extended to 32 bits. The buffer shows its head at all times, so the output data is valid before the pop.
- R3: Status bits [7:0] give the stored byte count modulo 256. Bit 8 (full) is set when fewer free bytes remain than one unit. Bit 9 (empty) is set when fewer bytes are stored than one unit. At 256 stored bytes the status reads 10'h100.
- R4: An operation write with bit 0 set empties the buffer in the next cycle. An operation write with bit 1 set enters `ST_RUNNING`, so `eng_ready` is high in the next cycle. Both bits may be set in one write.
- R5: An operation write with bit 1 clear enters `ST_STOPPED`. While stopped, `eng_ready` is low and engine transfers are ignored without an error. Stored data is kept, and the register side still pushes or pops.
- R6: Control bits [9:2] hold an 8-bit threshold compared with the byte count. With `IS_TX`=1, `thr_hit` is high when the count is at or below the threshold. With `IS_TX`=0, it is high when the count is at or above it.
- R7: The mark register holds three 6-bit marks compared with the word count (byte count divided by 4): stop in bits [5:0], low in bits [15:10], high in bits [25:20]. `chk_stop_hit` is high when the word count is at or above the stop mark. `chk_low_hit` is high when it is at or below the low mark. `chk_high_hit` is high when it is at or above the high mark.
- R8: A push while full or a pop while empty is refused and leaves the level unchanged. `err_pulse` is high for exactly the cycle after the refused transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 10 | Threshold [9:2] and unit code [1:0] |
| chk_we | input | 1 | Write strobe for the mark register |
| chk_wdata | input | 26 | High mark [25:20], low mark [15:10], stop mark [5:0] |
| op_we | input | 1 | Write strobe for the operation register |
| op_wdata | input | 2 | Start [1], flush [0] |
| host_xfer | input | 1 | Register-side transfer: push if IS_TX=1, pop otherwise |
| host_wdata | input | 32 | Register-side push data |
| host_rdata | output | 32 | Register-side head data (zero when IS_TX=1) |
| eng_xfer | input | 1 | Engine-side transfer: pop if IS_TX=1, push otherwise |
| eng_wdata | input | 32 | Engine-side push data |
| eng_rdata | output | 32 | Engine-side head data (zero when IS_TX=0) |
| eng_ready | output | 1 | Engine side enabled (controller running) |
| stat_word | output | 10 | Empty [9], full [8], byte level [7:0] |
| thr_hit | output | 1 | Threshold reached |
| full_evt | output | 1 | Full event flag |
| empty_evt | output | 1 | Empty event flag |
| chk_stop_hit | output | 1 | Word level at or above stop mark |
| chk_low_hit | output | 1 | Word level at or below low mark |
| chk_high_hit | output | 1 | Word level at or above high mark |
| err_pulse | output | 1 | One-cycle refusal indication |

## Verification
The overflow and underflow properties check only cycles in which the refused side is the only request and no operation write occurs. A concurrent pop or flush in such a cycle could legitimately move the level. The stimulus drives one transfer at a time and never writes the control register in the same cycle as a transfer. Every check therefore falls into the quiet windows the properties expect. The unit code is changed only while no transfer is pending, so the full and empty status always refer to the unit in force at the sampling edge.

// File: rtl/lvlfifo_pkg.sv
package lvlfifo_pkg;

    typedef enum logic [1:0] {
        UW_BYTE = 2'd0,
        UW_HALF = 2'd1,
        UW_WORD = 2'd2,
        UW_RSVD = 2'd3
    } unit_w_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_st_e;

    typedef struct packed {
        logic [5:0] high;
        logic [5:0] low;
        logic [5:0] stop;
    } marks_t;

    // bytes moved by one transfer for a unit code
    function automatic logic [2:0] unit_bytes(input logic [1:0] code);
        unique case (code)
            UW_BYTE: return 3'd1;
            UW_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lvlfifo_ctl.sv
module lvlfifo_ctl
    import lvlfifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [9:0]  ctrl_wdata,
    input  logic        chk_we,
    input  logic [25:0] chk_wdata,
    input  logic        op_we,
    input  logic [1:0]  op_wdata,
    output logic [1:0]  unit_code,
    output logic [7:0]  thr,
    output marks_t      marks,
    output logic        running,
    output logic        flush
);

    run_st_e state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nxt;
    end

    // transitions: START and HALT
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOPPED: if (op_we && op_wdata[1])  state_nxt = ST_RUNNING;
            ST_RUNNING: if (op_we && !op_wdata[1]) state_nxt = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        running = (state == ST_RUNNING);
        flush   = op_we && op_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_code <= UW_BYTE;
            thr       <= '0;
            marks     <= '0;
        end else begin
            if (ctrl_we) begin
                unit_code <= ctrl_wdata[1:0];
                thr       <= ctrl_wdata[9:2];
            end
            if (chk_we) begin
                marks.stop <= chk_wdata[5:0];
                marks.low  <= chk_wdata[15:10];
                marks.high <= chk_wdata[25:20];
            end
        end
    end

endmodule

// File: rtl/lvlfifo_flags.sv
module lvlfifo_flags
    import lvlfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter bit IS_TX = 1'b1,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       unit_code,
    input  logic [7:0]       thr,
    input  marks_t           marks,
    output logic             full,
    output logic             empty,
    output logic [9:0]       stat_word,
    output logic             thr_hit,
    output logic             stop_hit,
    output logic             low_hit,
    output logic             high_hit
);

    logic [31:0] cnt32, free32, nb32, words32;

    always_comb begin
        cnt32   = 32'(count);
        free32  = 32'(DEPTH) - cnt32;
        nb32    = 32'(unit_bytes(unit_code));
        words32 = cnt32 >> 2;
        full    = free32 < nb32;
        empty   = cnt32 < nb32;
        stat_word = {empty, full, cnt32[7:0]};
        stop_hit  = words32 >= 32'(marks.stop);
        low_hit   = words32 <= 32'(marks.low);
        high_hit  = words32 >= 32'(marks.high);
    end

    generate
        if (IS_TX) begin : g_tx_thr
            assign thr_hit = cnt32 <= 32'(thr);
        end else begin : g_rx_thr
            assign thr_hit = cnt32 >= 32'(thr);
        end
    endgenerate

endmodule

// File: rtl/lvlfifo_store.sv
module lvlfifo_store
    import lvlfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       unit_code,
    input  logic             full,
    input  logic             empty,
    input  logic             push_req,
    input  logic [31:0]      push_data,
    input  logic             pop_req,
    output logic [31:0]      pop_data,
    output logic [CNT_W-1:0] count,
    output logic             err_pulse
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [2:0]       nb;
    logic             push_ok, pop_ok;

    assign nb      = unit_bytes(unit_code);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            for (int k = 0; k < 4; k++) begin
                if (k < int'(nb)) mem[wptr + PTR_W'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_rd
        assign pop_data[8*k +: 8] = (k < int'(nb)) ? mem[rptr + PTR_W'(k)] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= (push_req && !push_ok) || (pop_req && !pop_ok);
            if (flush) begin
                wptr  <= '0;
                rptr  <= '0;
                count <= '0;
            end else begin
                if (push_ok) wptr <= wptr + PTR_W'(nb);
                if (pop_ok)  rptr <= rptr + PTR_W'(nb);
                count <= count + (push_ok ? CNT_W'(nb) : '0) - (pop_ok ? CNT_W'(nb) : '0);
            end
        end
    end

endmodule

// File: rtl/lvlfifo_top.sv
module lvlfifo_top
    import lvlfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter bit IS_TX = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [9:0]  ctrl_wdata,
    input  logic        chk_we,
    input  logic [25:0] chk_wdata,
    input  logic        op_we,
    input  logic [1:0]  op_wdata,
    input  logic        host_xfer,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        eng_xfer,
    input  logic [31:0] eng_wdata,
    output logic [31:0] eng_rdata,
    output logic        eng_ready,
    output logic [9:0]  stat_word,
    output logic        thr_hit,
    output logic        full_evt,
    output logic        empty_evt,
    output logic        chk_stop_hit,
    output logic        chk_low_hit,
    output logic        chk_high_hit,
    output logic        err_pulse
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [1:0]       unit_code;
    logic [7:0]       thr;
    marks_t           marks;
    logic             running, flush, full, empty;
    logic             push_req, pop_req, eng_go;
    logic [31:0]      push_data, pop_data;
    logic [CNT_W-1:0] count;

    lvlfifo_ctl u_ctl (
        .clk, .rst_n, .ctrl_we, .ctrl_wdata, .chk_we, .chk_wdata,
        .op_we, .op_wdata, .unit_code, .thr, .marks, .running, .flush
    );

    // engine side only moves data while running
    assign eng_go    = eng_xfer && running;
    assign eng_ready = running;
    assign push_req  = IS_TX ? host_xfer  : eng_go;
    assign pop_req   = IS_TX ? eng_go     : host_xfer;
    assign push_data = IS_TX ? host_wdata : eng_wdata;
    assign host_rdata = IS_TX ? 32'h0 : pop_data;
    assign eng_rdata  = IS_TX ? pop_data : 32'h0;

    lvlfifo_flags #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_flags (
        .count, .unit_code, .thr, .marks, .full, .empty, .stat_word,
        .thr_hit, .stop_hit(chk_stop_hit), .low_hit(chk_low_hit),
        .high_hit(chk_high_hit)
    );

    lvlfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk, .rst_n, .flush, .unit_code, .full, .empty,
        .push_req, .push_data, .pop_req, .pop_data, .count, .err_pulse
    );

    assign full_evt  = full;
    assign empty_evt = empty;

endmodule

// File: rtl/lvlfifo_chk.sv
module lvlfifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_we,
    input logic [1:0] op_wdata,
    input logic       eng_ready,
    input logic [9:0] stat_word,
    input logic       err_pulse,
    input logic       push_req,
    input logic       pop_req
);

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_word[8] && stat_word[9])); // R3

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        op_we && op_wdata[0] |=> (stat_word[7:0] == 8'h00) && stat_word[9]); // R4

    AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_we && op_wdata[1] |=> eng_ready); // R4

    AST_STOP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_we && !op_wdata[1] |=> !eng_ready); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && stat_word[8] && !pop_req && !op_we |=> err_pulse && $stable(stat_word[7:0])); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && stat_word[9] && !push_req && !op_we |=> err_pulse && $stable(stat_word[7:0])); // R8

endmodule

bind lvlfifo_top lvlfifo_chk u_chk (
    .clk, .rst_n, .op_we, .op_wdata, .eng_ready, .stat_word,
    .err_pulse, .push_req, .pop_req
);

// File: tb/lvlfifo_top_tb.sv
module lvlfifo_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_we, chk_we, op_we, host_xfer, eng_xfer;
    logic [9:0]  ctrl_wdata;
    logic [25:0] chk_wdata;
    logic [1:0]  op_wdata;
    logic [31:0] host_wdata, host_rdata, eng_wdata, eng_rdata;
    logic        eng_ready, thr_hit, full_evt, empty_evt, err_pulse;
    logic        chk_stop_hit, chk_low_hit, chk_high_hit;
    logic [9:0]  stat_word;

    logic        rx_ctrl_we, rx_op_we, rx_host_xfer, rx_eng_xfer;
    logic [9:0]  rx_ctrl_wdata;
    logic [1:0]  rx_op_wdata;
    logic [31:0] rx_eng_wdata, rx_host_rdata, rx_eng_rdata;
    logic        rx_ready, rx_thr, rx_full, rx_empty, rx_err, rx_s, rx_l, rx_h;
    logic [9:0]  rx_stat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [1:0] cur_w = 2'd0;
    logic [7:0] cur_thr = 8'd0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    lvlfifo_top #(.DEPTH(256), .IS_TX(1'b1)) u_dut (
        .clk, .rst_n, .ctrl_we, .ctrl_wdata, .chk_we, .chk_wdata, .op_we, .op_wdata,
        .host_xfer, .host_wdata, .host_rdata, .eng_xfer, .eng_wdata, .eng_rdata,
        .eng_ready, .stat_word, .thr_hit, .full_evt, .empty_evt,
        .chk_stop_hit, .chk_low_hit, .chk_high_hit, .err_pulse
    );

    lvlfifo_top #(.DEPTH(256), .IS_TX(1'b0)) u_dut_rx (
        .clk, .rst_n, .ctrl_we(rx_ctrl_we), .ctrl_wdata(rx_ctrl_wdata),
        .chk_we(1'b0), .chk_wdata(26'd0), .op_we(rx_op_we), .op_wdata(rx_op_wdata),
        .host_xfer(rx_host_xfer), .host_wdata(32'd0), .host_rdata(rx_host_rdata),
        .eng_xfer(rx_eng_xfer), .eng_wdata(rx_eng_wdata), .eng_rdata(rx_eng_rdata),
        .eng_ready(rx_ready), .stat_word(rx_stat), .thr_hit(rx_thr),
        .full_evt(rx_full), .empty_evt(rx_empty), .chk_stop_hit(rx_s),
        .chk_low_hit(rx_l), .chk_high_hit(rx_h), .err_pulse(rx_err)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    task automatic set_ctrl(input logic [1:0] w, input logic [7:0] t);
        cur_w = w;
        cur_thr = t;
        ctrl_we = 1'b1;
        ctrl_wdata = {t, w};
        cyc();
        ctrl_we = 1'b0;
    endtask

    task automatic op_write(input logic [1:0] v);
        op_we = 1'b1;
        op_wdata = v;
        cyc();
        op_we = 1'b0;
        if (v[0]) exp_q.delete();
    endtask

    // driver: pushes a unit and records the expected bytes
    task automatic host_push(input string req, input logic [31:0] d);
        int nb;
        bit fits;
        nb = nbytes(cur_w);
        fits = (256 - exp_q.size()) >= nb;
        host_xfer = 1'b1;
        host_wdata = d;
        cyc();
        host_xfer = 1'b0;
        if (fits) begin
            for (int k = 0; k < nb; k++) exp_q.push_back(d[8*k +: 8]);
            check(req, {31'd0, err_pulse}, 32'd0);
        end else begin
            check(req, {31'd0, err_pulse}, 32'd1);
        end
    endtask

    // monitor: compares the head against the scoreboard, then pops
    task automatic eng_pop(input string req);
        int nb;
        logic [31:0] e;
        nb = nbytes(cur_w);
        e = '0;
        if (exp_q.size() >= nb) begin
            for (int k = 0; k < nb; k++) e[8*k +: 8] = exp_q[k];
            check(req, eng_rdata, e);
            eng_xfer = 1'b1;
            cyc();
            eng_xfer = 1'b0;
            for (int k = 0; k < nb; k++) void'(exp_q.pop_front());
            check(req, {31'd0, err_pulse}, 32'd0);
        end else begin
            eng_xfer = 1'b1;
            cyc();
            eng_xfer = 1'b0;
            check(req, {31'd0, err_pulse}, 32'd1);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ctrl_we = 0; chk_we = 0; op_we = 0; host_xfer = 0; eng_xfer = 0;
        ctrl_wdata = '0; chk_wdata = '0; op_wdata = '0; host_wdata = '0; eng_wdata = '0;
        rx_ctrl_we = 0; rx_op_we = 0; rx_host_xfer = 0; rx_eng_xfer = 0;
        rx_ctrl_wdata = '0; rx_op_wdata = '0; rx_eng_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status", 32'(stat_word), 32'h200);
        check("R1 ready", 32'(eng_ready), 32'd0);
        check("R1 err", 32'(err_pulse), 32'd0);

        // R5 register side works while stopped, engine side ignored
        host_push("R5 push stopped", 32'h0000_00A5);
        check("R5 level", 32'(stat_word), 32'h001);
        eng_xfer = 1'b1; cyc(); eng_xfer = 1'b0;
        check("R5 ignored pop level", 32'(stat_word), 32'h001);
        check("R5 ignored pop no err", 32'(err_pulse), 32'd0);

        // R4 start keeps contents
        op_write(2'b10);
        check("R4 ready", 32'(eng_ready), 32'd1);
        check("R4 kept", 32'(stat_word), 32'h001);
        eng_pop("R2 byte pop");
        check("R3 empty byte", 32'(stat_word), 32'h200);

        // R2 word pushes, R7 marks
        set_ctrl(2'd2, 8'd0);
        host_push("R2 word", 32'h1122_3344);
        host_push("R2 word", 32'h5566_7788);
        host_push("R2 word", 32'h99AA_BBCC);
        check("R3 level 12", 32'(stat_word), 32'h00C);
        chk_we = 1'b1;
        chk_wdata = (26'd5 << 20) | (26'd2 << 10) | 26'd3;
        cyc();
        chk_we = 1'b0;
        check("R7 stop at 3", 32'(chk_stop_hit), 32'd1);
        check("R7 low at 3", 32'(chk_low_hit), 32'd0);
        check("R7 high at 3", 32'(chk_high_hit), 32'd0);
        eng_pop("R2 word pop");
        check("R7 stop at 2", 32'(chk_stop_hit), 32'd0);
        check("R7 low at 2", 32'(chk_low_hit), 32'd1);

        // R2 mixed widths over the byte store
        set_ctrl(2'd1, 8'd0);
        eng_pop("R2 half pop");
        eng_pop("R2 half pop");
        set_ctrl(2'd0, 8'd0);
        eng_pop("R2 byte after word");
        eng_pop("R2 byte after word");
        set_ctrl(2'd3, 8'd0);
        host_push("R2 code3 push", 32'hDEAD_BEEF);
        check("R2 code3 is four bytes", 32'(stat_word), 32'h006);
        set_ctrl(2'd0, 8'd0);
        eng_pop("R2 byte");
        eng_pop("R2 byte");
        set_ctrl(2'd2, 8'd0);
        eng_pop("R2 word tail");
        check("R3 empty word", 32'(stat_word), 32'h200);

        // R3 and R8 full
        for (int i = 0; i < 64; i++) host_push("R3 fill", 32'hC000_0000 + 32'(i * 7));
        check("R3 full status", 32'(stat_word), 32'h100);
        check("R3 full event", 32'(full_evt), 32'd1);
        host_push("R8 overflow err", 32'hFFFF_FFFF);
        check("R8 overflow level", 32'(stat_word), 32'h100);
        cyc();
        check("R8 err one cycle", 32'(err_pulse), 32'd0);
        for (int i = 0; i < 64; i++) eng_pop("R2 drain");
        eng_pop("R8 underflow err");
        check("R8 underflow level", 32'(stat_word), 32'h200);

        // R6 transmit threshold
        set_ctrl(2'd0, 8'd8);
        for (int i = 0; i < 9; i++) host_push("R6 fill", 32'(i + 1));
        check("R6 tx above thr", 32'(thr_hit), 32'd0);
        eng_pop("R6 pop");
        check("R6 tx at thr", 32'(thr_hit), 32'd1);

        // R4 flush with start, R5 stop
        op_write(2'b11);
        check("R4 flush status", 32'(stat_word), 32'h200);
        check("R4 flush running", 32'(eng_ready), 32'd1);
        op_write(2'b00);
        check("R5 stop ready", 32'(eng_ready), 32'd0);

        // R6 receive threshold on the second instance
        rx_ctrl_we = 1'b1; rx_ctrl_wdata = {8'd4, 2'd0}; cyc(); rx_ctrl_we = 1'b0;
        rx_op_we = 1'b1; rx_op_wdata = 2'b10; cyc(); rx_op_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rx_eng_xfer = 1'b1; rx_eng_wdata = 32'h40 + 32'(i); cyc(); rx_eng_xfer = 1'b0;
        end
        check("R6 rx below thr", 32'(rx_thr), 32'd0);
        rx_eng_xfer = 1'b1; rx_eng_wdata = 32'h43; cyc(); rx_eng_xfer = 1'b0;
        check("R6 rx at thr", 32'(rx_thr), 32'd1);
        check("R2 rx head", rx_host_rdata, 32'h40);
        rx_host_xfer = 1'b1; cyc(); rx_host_xfer = 1'b0;
        check("R2 rx next", rx_host_rdata, 32'h41);
        check("R6 rx below again", 32'(rx_thr), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule